// File: doc/BRIEF.md
# Serial Sample Frame Command Decoder

This block terminates the transmit side of a three-wire serial sample link. The link carries a serial clock, a frame-start strobe and one data line. Each frame holds 16 bits: a 4-bit command, two unused bits and a 10-bit payload, sent MSB first. The command says what to do with the payload. It can deliver a DAC sample, optionally retune a 4-bit predriver gain on the fly, or drive a byte-wise indirect access port into a register bank. That access port uses a pointer that steps forward automatically.

The three link wires are oversampled by the block's own clock `clk`. Each wire passes through a synchronizer, then an edge detector on the serial clock. A deframer state machine (`FR_IDLE`, `FR_SKIP`, `FR_SHIFT`, `FR_DONE`) collects the bits. It has these transitions:
- IDLE→SHIFT or IDLE→SKIP on a frame start.
- SKIP→SHIFT on the next serial-clock falling edge.
- SHIFT→DONE on the sixteenth captured bit.
- DONE→IDLE after one cycle.
- From any state, a new frame start re-enters SHIFT or SKIP.

A command executor holds an access mode (`ACC_WRITE`, `ACC_READ`). It changes mode only on an address command. Two configuration inputs set the frame alignment: which serial-clock edge samples the strobe, and whether the first bit is delayed by one cycle. Each serial-clock half period must last at least two `clk` cycles.

Top module: `txframe_cmd_decoder`

## Requirements
- R1: After reset, `gain` is 4'b0101, `smp_valid`, `acc_wr` and `acc_rd` are low, and the pointer and the 16-bit data holding register are zero.
- R2: Data bits are taken on serial-clock falling edges. Frame bits [15:12] are the command, bits [11:10] are ignored, and bits [9:0] are the payload, all sent MSB first. A command with bit 3 = 0 gives a one-cycle `smp_valid` pulse with `smp_data` equal to the payload.
- R3: The strobe is sampled on the serial-clock falling edge when `cfg_conv_on_rise`=0 and on the rising edge when it is 1. A frame starts when the sampled strobe changes from low to high.
- R4: With `cfg_data_late`=0, the command MSB is the bit on the falling edge of the serial-clock cycle in which the strobe was first seen high. With `cfg_data_late`=1, it is the bit on the next falling edge. This holds in both strobe modes.
- R5: With `cfg_dyn_gain`=1, a data frame whose command bits [2:0] are c≠0 sets `gain` as follows: 1→0001, 2→0010, 3→0011, 4→0101, 5→0110, 6→0111, 7→1000. The value c=0 leaves `gain` unchanged.
- R6: With `cfg_dyn_gain`=0, data frames never change `gain`.
- R7: Command 4'b1000 loads the pointer from payload[6:0] and the access mode from payload[7] (0 write, 1 read). It produces no strobe.
- R8: In write mode, 4'b1001 stores payload[7:0] as the upper data byte with no strobe. 4'b1010 stores payload[7:0] as the lower byte and pulses `acc_wr` for one cycle with `acc_addr` equal to the pointer and `acc_wdata` equal to {upper, lower}. The pointer then steps by one.
- R9: In read mode, 4'b1001 pulses `acc_rd` with `acc_rd_hi`=1 at the pointer and leaves the pointer unchanged. 4'b1010 pulses `acc_rd` with `acc_rd_hi`=0 at the pointer, and the pointer then steps by one.
- R10: Commands 4'b1011 and 4'b11xx produce no strobe and change neither the gain, the pointer, the mode nor the data bytes.
- R11: A frame start before sixteen bits have been taken abandons the partial frame. This includes a start on the same falling edge that would have carried the sixteenth bit.
- R12: The 7-bit pointer wraps from 127 to 0 when it steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_conv_on_rise | input | 1 | 1: strobe sampled on serial-clock rising edge; 0: falling |
| cfg_data_late | input | 1 | 1: first frame bit one serial cycle after the strobe cycle |
| cfg_dyn_gain | input | 1 | Enables gain updates from data frames |
| ser_clk | input | 1 | Serial link clock |
| ser_conv | input | 1 | Serial frame-start strobe |
| ser_dat | input | 1 | Serial data |
| smp_valid | output | 1 | One-cycle pulse: new sample |
| smp_data | output | 10 | Sample value |
| gain | output | 4 | Predriver gain setting |
| acc_addr | output | 7 | Register address of the current access |
| acc_wdata | output | 16 | Assembled write data |
| acc_wr | output | 1 | One-cycle register write strobe |
| acc_rd | output | 1 | One-cycle register read strobe |
| acc_rd_hi | output | 1 | Read strobe targets the upper byte |

## Verification
In falling-edge strobe mode, the completion of one frame and the start of the next can fall on the same serial-clock falling edge. On that edge the sixteenth bit of the old frame and the strobe of the new frame arrive together. The bench provokes this by cutting a frame after fifteen bits and starting a new frame in the very next bit slot. The scoreboard expects only the new frame's result, so any strobe produced by the abandoned frame shows up as a mismatch. The same cut is repeated in rising-edge mode and with a shorter partial frame.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SKIP  = 2'd1,
        FR_SHIFT = 2'd2,
        FR_DONE  = 2'd3
    } fr_state_e;

    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } acc_mode_e;

    typedef logic [3:0] gain_t;

    localparam gain_t            GAIN_RESET = 4'b0101;
    localparam logic [CMD_W-1:0] CMD_ADDR   = 4'b1000;
    localparam logic [CMD_W-1:0] CMD_HIGH   = 4'b1001;
    localparam logic [CMD_W-1:0] CMD_LOW    = 4'b1010;

    // Gain code 1..3 maps straight through; 4..7 skips setting 0100.
    function automatic gain_t gain_lookup(input logic [2:0] code);
        gain_t g;
        g = {1'b0, code} + {3'b000, code[2]};
        return g;
    endfunction

endpackage

// File: rtl/txf_pin_sync.sv
module txf_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_conv,
    input  logic ser_dat,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic conv_lvl,
    output logic dat_lvl
);
    localparam int LAST = STAGES - 1;

    logic [2:0] chain [STAGES];
    logic       sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= {ser_clk, ser_conv, ser_dat};
        end
    end

    generate
        for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[gi] <= '0;
                end else begin
                    chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= chain[LAST][2];
        end
    end

    assign sclk_rise = chain[LAST][2] & ~sclk_prev;
    assign sclk_fall = ~chain[LAST][2] & sclk_prev;
    assign conv_lvl  = chain[LAST][1];
    assign dat_lvl   = chain[LAST][0];

endmodule

// File: rtl/txf_deframer.sv
module txf_deframer
    import txf_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_conv_on_rise,
    input  logic               cfg_data_late,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               conv_lvl,
    input  logic               dat_lvl,
    output logic               frm_valid,
    output logic [FRAME_W-1:0] frm_word
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    fr_state_e          state, state_nxt;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               conv_prev;
    logic               conv_evt;
    logic               start;
    logic               shift_en;
    logic               cnt_clr;

    assign conv_evt = cfg_conv_on_rise ? sclk_rise : sclk_fall;
    assign start    = conv_evt & conv_lvl & ~conv_prev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and datapath enables
    always_comb begin
        state_nxt = state;
        shift_en  = 1'b0;
        cnt_clr   = 1'b0;
        if (start) begin
            cnt_clr = 1'b1;
            if (cfg_conv_on_rise && cfg_data_late) begin
                state_nxt = FR_SKIP;
            end else begin
                state_nxt = FR_SHIFT;
                shift_en  = !cfg_conv_on_rise && !cfg_data_late;
            end
        end else begin
            unique case (state)
                FR_IDLE: state_nxt = FR_IDLE;
                FR_SKIP: begin
                    if (sclk_fall) state_nxt = FR_SHIFT;
                end
                FR_SHIFT: begin
                    if (sclk_fall) begin
                        shift_en = 1'b1;
                        if (cnt == LAST_BIT) state_nxt = FR_DONE;
                    end
                end
                FR_DONE: state_nxt = FR_IDLE;
                default: state_nxt = FR_IDLE;
            endcase
        end
    end

    // Shift register, bit counter, strobe history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            conv_prev <= 1'b0;
        end else begin
            if (conv_evt) conv_prev <= conv_lvl;
            if (shift_en) shreg <= {shreg[FRAME_W-2:0], dat_lvl};
            if (cnt_clr) begin
                cnt <= shift_en ? CNT_W'(1) : '0;
            end else if (shift_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    assign frm_valid = (state == FR_DONE);
    assign frm_word  = shreg;

    a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);

    a_r2_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> $past(sclk_fall));

    a_r4_skip_needs_rise_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_SKIP) |-> cfg_conv_on_rise);

    a_r11_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt <= CNT_W'(1)) && (state != FR_DONE));

endmodule

// File: rtl/txf_cmd_exec.sv
module txf_cmd_exec
    import txf_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int SMP_W   = 10,
    parameter int ADDR_W  = 7,
    parameter int BYTE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_dyn_gain,
    input  logic                frm_valid,
    input  logic [FRAME_W-1:0]  frm_word,
    output logic                smp_valid,
    output logic [SMP_W-1:0]    smp_data,
    output gain_t               gain,
    output logic [ADDR_W-1:0]   acc_addr,
    output logic [2*BYTE_W-1:0] acc_wdata,
    output logic                acc_wr,
    output logic                acc_rd,
    output logic                acc_rd_hi
);
    localparam int MODE_BIT = BYTE_W - 1;

    logic [CMD_W-1:0]  cmd;
    logic [SMP_W-1:0]  payload;
    acc_mode_e         mode;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] byte_hi, byte_lo;

    assign cmd     = frm_word[FRAME_W-1 -: CMD_W];
    assign payload = frm_word[SMP_W-1:0];

    // Access mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= ACC_WRITE;
        end else if (frm_valid && cmd == CMD_ADDR) begin
            mode <= acc_mode_e'(payload[MODE_BIT]);
        end
    end

    // Command execution and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
            gain      <= GAIN_RESET;
            acc_addr  <= '0;
            acc_wr    <= 1'b0;
            acc_rd    <= 1'b0;
            acc_rd_hi <= 1'b0;
            ptr       <= '0;
            byte_hi   <= '0;
            byte_lo   <= '0;
        end else begin
            smp_valid <= 1'b0;
            acc_wr    <= 1'b0;
            acc_rd    <= 1'b0;
            if (frm_valid) begin
                if (!cmd[CMD_W-1]) begin
                    smp_valid <= 1'b1;
                    smp_data  <= payload;
                    if (cfg_dyn_gain && cmd[2:0] != 3'b000) begin
                        gain <= gain_lookup(cmd[2:0]);
                    end
                end else begin
                    case (cmd)
                        CMD_ADDR: ptr <= payload[ADDR_W-1:0];
                        CMD_HIGH: begin
                            if (mode == ACC_WRITE) begin
                                byte_hi <= payload[BYTE_W-1:0];
                            end else begin
                                acc_rd    <= 1'b1;
                                acc_rd_hi <= 1'b1;
                                acc_addr  <= ptr;
                            end
                        end
                        CMD_LOW: begin
                            acc_addr <= ptr;
                            ptr      <= ptr + 1'b1;
                            if (mode == ACC_WRITE) begin
                                byte_lo <= payload[BYTE_W-1:0];
                                acc_wr  <= 1'b1;
                            end else begin
                                acc_rd    <= 1'b1;
                                acc_rd_hi <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign acc_wdata = {byte_hi, byte_lo};

    a_r5_gain_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (gain != 4'b0000) && (gain != 4'b0100) && (gain <= 4'b1000));

    a_r6_gain_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (gain != $past(gain)) |-> $past(frm_valid && cfg_dyn_gain));

    a_r8_write_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> $past(frm_valid));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smp_valid, acc_wr, acc_rd}));

    a_r12_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr || (acc_rd && !acc_rd_hi)) |-> (ptr == ADDR_W'(acc_addr + 1'b1)));

endmodule

// File: rtl/txframe_cmd_decoder.sv
module txframe_cmd_decoder
    import txf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_W     = 16,
    parameter int SMP_W       = 10,
    parameter int ADDR_W      = 7,
    parameter int BYTE_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_conv_on_rise,
    input  logic                cfg_data_late,
    input  logic                cfg_dyn_gain,
    input  logic                ser_clk,
    input  logic                ser_conv,
    input  logic                ser_dat,
    output logic                smp_valid,
    output logic [SMP_W-1:0]    smp_data,
    output logic [3:0]          gain,
    output logic [ADDR_W-1:0]   acc_addr,
    output logic [2*BYTE_W-1:0] acc_wdata,
    output logic                acc_wr,
    output logic                acc_rd,
    output logic                acc_rd_hi
);
    logic               sclk_rise, sclk_fall, conv_lvl, dat_lvl;
    logic               frm_valid;
    logic [FRAME_W-1:0] frm_word;

    txf_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_conv  (ser_conv),
        .ser_dat   (ser_dat),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .conv_lvl  (conv_lvl),
        .dat_lvl   (dat_lvl)
    );

    txf_deframer #(.FRAME_W(FRAME_W)) u_deframe (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_conv_on_rise (cfg_conv_on_rise),
        .cfg_data_late    (cfg_data_late),
        .sclk_rise        (sclk_rise),
        .sclk_fall        (sclk_fall),
        .conv_lvl         (conv_lvl),
        .dat_lvl          (dat_lvl),
        .frm_valid        (frm_valid),
        .frm_word         (frm_word)
    );

    txf_cmd_exec #(
        .FRAME_W (FRAME_W),
        .SMP_W   (SMP_W),
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W)
    ) u_exec (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_dyn_gain (cfg_dyn_gain),
        .frm_valid    (frm_valid),
        .frm_word     (frm_word),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .gain         (gain),
        .acc_addr     (acc_addr),
        .acc_wdata    (acc_wdata),
        .acc_wr       (acc_wr),
        .acc_rd       (acc_rd),
        .acc_rd_hi    (acc_rd_hi)
    );

endmodule

// File: tb/sim_txframe_cmd_decoder.sv
`timescale 1ns/1ps
module sim_txframe_cmd_decoder;

    localparam int HP = 4;

    typedef struct {
        int          kind;   // 0 sample, 1 write, 2 read
        logic [15:0] data;
        logic [6:0]  addr;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_conv_on_rise = 1'b0;
    logic        cfg_data_late = 1'b0;
    logic        cfg_dyn_gain = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_conv = 1'b0;
    logic        ser_dat = 1'b0;
    logic        smp_valid;
    logic [9:0]  smp_data;
    logic [3:0]  gain;
    logic [6:0]  acc_addr;
    logic [15:0] acc_wdata;
    logic        acc_wr, acc_rd, acc_rd_hi;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    item_t q[$];

    // bench-side expectation state
    logic [3:0] m_gain = 4'b0101;
    logic [6:0] m_ptr = '0;
    logic       m_rd = 1'b0;
    logic [7:0] m_hi = '0, m_lo = '0;

    always #2.5 clk = ~clk;

    txframe_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_conv_on_rise(cfg_conv_on_rise), .cfg_data_late(cfg_data_late),
        .cfg_dyn_gain(cfg_dyn_gain),
        .ser_clk(ser_clk), .ser_conv(ser_conv), .ser_dat(ser_dat),
        .smp_valid(smp_valid), .smp_data(smp_data), .gain(gain),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_rd_hi(acc_rd_hi)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_gain(input logic [2:0] c);
        case (c)
            3'd1: return 4'b0001;
            3'd2: return 4'b0010;
            3'd3: return 4'b0011;
            3'd4: return 4'b0101;
            3'd5: return 4'b0110;
            3'd6: return 4'b0111;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic void push(input int k, input logic [15:0] d,
                                 input logic [6:0] a, input string t);
        item_t it;
        it.kind = k; it.data = d; it.addr = a; it.tag = t;
        q.push_back(it);
    endfunction

    // expectation model built from the requirements
    function automatic void expect_frame(input logic [15:0] w, input string t);
        logic [3:0] c;
        logic [9:0] p;
        c = w[15:12];
        p = w[9:0];
        if (!c[3]) begin
            push(0, {6'd0, p}, '0, t);
            if (cfg_dyn_gain && c[2:0] != 3'd0) m_gain = exp_gain(c[2:0]);
        end else if (c == 4'b1000) begin
            m_ptr = p[6:0];
            m_rd  = p[7];
        end else if (c == 4'b1001) begin
            if (!m_rd) m_hi = p[7:0];
            else push(2, 16'd1, m_ptr, t);
        end else if (c == 4'b1010) begin
            if (!m_rd) begin
                m_lo = p[7:0];
                push(1, {m_hi, m_lo}, m_ptr, t);
            end else begin
                push(2, 16'd0, m_ptr, t);
            end
            m_ptr = m_ptr + 7'd1;
        end
    endfunction

    task automatic slot(input logic c, input logic d);
        @(negedge clk);
        ser_conv = c;
        ser_dat  = d;
        repeat (HP) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HP) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) slot(1'b0, 1'b0);
    endtask

    task automatic send_bits(input logic [15:0] w, input int nbits);
        for (int s = 0; s < nbits + int'(cfg_data_late); s++) begin
            int bi;
            bi = s - int'(cfg_data_late);
            slot(s == 0, (bi < 0) ? 1'b0 : w[15 - bi]);
        end
    endtask

    task automatic send(input logic [15:0] w, input string t);
        expect_frame(w, t);
        send_bits(w, 16);
        gap(2);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (smp_valid || acc_wr || acc_rd)) begin
            int k;
            k = smp_valid ? 0 : (acc_wr ? 1 : 2);
            if (q.size() == 0) begin
                check(1'b0, "R10 unexpected strobe", k, -1);
            end else begin
                item_t it;
                it = q.pop_front();
                check(k == it.kind, {it.tag, " kind"}, k, it.kind);
                if (it.kind == 0 && k == 0)
                    check(smp_data == it.data[9:0], {it.tag, " sample"}, smp_data, it.data);
                if (it.kind == 1 && k == 1) begin
                    check(acc_addr == it.addr, {it.tag, " wr addr"}, acc_addr, it.addr);
                    check(acc_wdata == it.data, {it.tag, " wr data"}, acc_wdata, it.data);
                end
                if (it.kind == 2 && k == 2) begin
                    check(acc_addr == it.addr, {it.tag, " rd addr"}, acc_addr, it.addr);
                    check(acc_rd_hi == it.data[0], {it.tag, " rd byte"}, acc_rd_hi, it.data[0]);
                end
            end
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(gain == 4'b0101, "R1 gain", gain, 5);
        check(!smp_valid && !acc_wr && !acc_rd, "R1 strobes", {smp_valid, acc_wr, acc_rd}, 0);
        check(acc_wdata == 16'h0, "R1 data", acc_wdata, 0);
        gap(1);

        // R2 plain data frame, gain code 0
        send(16'h02A5, "R2");
        check(gain == m_gain, "R2 gain kept", gain, m_gain);
        send(16'h0C00 | 16'h13C, "R2 ignored bits");

        // R5 every gain code
        for (int c = 7; c >= 0; c--) begin
            send({1'b0, 3'(c), 2'b00, 10'(c * 37)}, "R5");
            check(gain == m_gain, "R5 gain", gain, m_gain);
        end

        // R3 strobe on rising edge, R4 late data in both modes
        cfg_conv_on_rise = 1'b1;
        send(16'h7155, "R3");
        check(gain == m_gain, "R3 gain", gain, m_gain);
        cfg_data_late = 1'b1;
        send(16'h23FF, "R4 rise late");
        cfg_conv_on_rise = 1'b0;
        send(16'h5201, "R4 fall late");
        check(gain == m_gain, "R4 gain", gain, m_gain);
        cfg_data_late = 1'b0;

        // R6 gain frozen
        cfg_dyn_gain = 1'b0;
        send(16'h1111, "R6");
        check(gain == 4'b0110, "R6 gain", gain, 6);
        cfg_dyn_gain = 1'b1;

        // R7, R8 indirect write
        send(16'h8012, "R7");
        send(16'h90AB, "R8 high");
        send(16'hA0CD, "R8 low");
        send(16'hA001, "R8 step");

        // R10 reserved commands
        send(16'hB3FF, "R10");
        send(16'hC07F, "R10");
        send(16'hF2FF, "R10");
        send(16'hA022, "R10 state kept");
        send(16'h0155, "R10 gain");
        check(gain == m_gain, "R10 gain", gain, m_gain);

        // R9 reads, R12 wrap
        send(16'h80FE, "R9 set");
        send(16'h9000, "R9 high");
        send(16'hA000, "R9 low");
        send(16'hA000, "R12 pre");
        send(16'hA000, "R12 wrap");
        send(16'h9000, "R12 wrapped");

        // R11 restart: partial frames abandoned
        send_bits(16'hFFFF, 10);
        send(16'h0321, "R11 partial");
        send_bits(16'h3FFF, 15);
        send(16'h0204, "R11 same fall");
        cfg_conv_on_rise = 1'b1;
        send_bits(16'h2FFF, 15);
        send(16'h0099, "R11 rise mode");
        cfg_conv_on_rise = 1'b0;

        check(q.size() == 0, "R2 all results seen", q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule